// File: doc/BRIEF.md
# Two-Timer Pulse-Width Modulator

This block produces a pulse-width-modulated output from two cooperating timers. A free-running period timer reloads itself and emits a single-cycle trigger at the start of every PWM period. Each trigger fires a second timer that behaves as a one-shot. The one-shot's output is the PWM signal: it rises at the trigger and stays high for a programmed number of clock cycles. Both timers reload on their own, so the waveform repeats with no control action once it is enabled.

The period and the high time are 16-bit cycle counts presented as plain inputs. They are sampled only in the trigger cycle, so every period is built from one consistent pair of settings. Changing the high time changes the mark/space ratio from the next period on. Deasserting the enable stops both timers and forces both outputs low. Reasserting it restarts the waveform with a trigger in the first enabled cycle.

Top module: `pwm2t_top`

## Requirements
- R1: While enabled, the trigger pulses once every P cycles, where P is the period input sampled at the previous trigger. Period values 0 and 1 both give a trigger in every cycle.
- R2: The trigger marks cycle 0 of each period, and the first trigger comes in the first cycle with enable high.
- R3: With a high time W where 0 < W < P, the PWM output is high in cycles 0 to W-1 of each period and low in cycles W to P-1.
- R4: A high time of 0 keeps the PWM output low for the whole period, the trigger cycle included.
- R5: A high time W >= P keeps the PWM output high for the whole period, with no low cycle at the period boundary.
- R6: The period and high-time inputs are sampled only in a trigger cycle. Changes made between triggers have no effect on the period in progress.
- R7: While enable is low, the PWM output and the trigger are both low, and both timers are held at their start state.
- R8: After reset, with enable low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Runs both timers when high; holds them and drives the outputs low when low |
| period_i | input | 16 | PWM period in clock cycles, sampled at each trigger |
| width_i | input | 16 | PWM high time in clock cycles, sampled at each trigger |
| pwm_o | output | 1 | PWM waveform (one-shot output) |
| trig_o | output | 1 | Single-cycle pulse marking cycle 0 of each period |

## Verification
Both outputs are decoded from the timer registers and the current inputs without a further register. Cycle k of a period is therefore visible during the k-th clock interval after the trigger interval, and the first enabled interval is cycle 0. The bench changes inputs on the falling edge and samples one time unit later, before the next rising edge. It compares the trigger and the PWM level in every cycle against (k mod P)==0 and (k mod P)<W. The expected values for the R6 and R7 sequences are worked out per cycle in the same way.

// File: rtl/pwm2t_pkg.sv
package pwm2t_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    // Period timer registers: running count and the period latched at the trigger
    typedef struct packed {
        cnt_t count;
        cnt_t span;
    } ptmr_state_t;

    // Count value that follows the trigger cycle for a freshly sampled period
    function automatic cnt_t first_step(input cnt_t span);
        return (span > cnt_t'(1)) ? cnt_t'(1) : cnt_t'(0);
    endfunction

    // Advance the count, wrapping to zero at the end of the period
    function automatic cnt_t wrap_step(input cnt_t count, input cnt_t span);
        logic [CNT_W:0] nxt;
        nxt = {1'b0, count} + 1'b1;
        return (nxt >= {1'b0, span}) ? cnt_t'(0) : nxt[CNT_W-1:0];
    endfunction

    // Remaining high cycles after the trigger cycle has been spent
    function automatic cnt_t load_remaining(input cnt_t width);
        return (width == cnt_t'(0)) ? cnt_t'(0) : width - cnt_t'(1);
    endfunction

endpackage

// File: rtl/pwm2t_period_tmr.sv
module pwm2t_period_tmr
    import pwm2t_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  cnt_t period_i,
    output logic trig_o
);

    ptmr_state_t st_q, st_d;

    assign trig_o = en_i && (st_q.count == cnt_t'(0));

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.count = '0;
        end else if (trig_o) begin
            st_d.span  = period_i;
            st_d.count = first_step(period_i);
        end else begin
            st_d.count = wrap_step(st_q.count, st_q.span);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Between triggers the count stays below the latched period
    assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !trig_o) |-> (st_q.count < st_q.span));

    // A trigger with a period above one is never followed by another trigger
    assert_trig_spacing_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (trig_o && period_i > cnt_t'(1)) |=> !trig_o);

    // Disabled timer sits at cycle 0 and fires on the next enabled cycle
    assert_restart_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i ##1 en_i) |-> trig_o);

endmodule

// File: rtl/pwm2t_oneshot.sv
module pwm2t_oneshot
    import pwm2t_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic fire_i,
    input  cnt_t width_i,
    output logic pulse_o
);

    cnt_t remain_q, remain_d;

    assign pulse_o = en_i && (fire_i ? (width_i != cnt_t'(0)) : (remain_q != cnt_t'(0)));

    always_comb begin
        remain_d = remain_q;
        if (!en_i) begin
            remain_d = '0;
        end else if (fire_i) begin
            remain_d = load_remaining(width_i);
        end else if (remain_q != cnt_t'(0)) begin
            remain_d = remain_q - cnt_t'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            remain_q <= '0;
        end else begin
            remain_q <= remain_d;
        end
    end

    assert_zero_width_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (fire_i && width_i == cnt_t'(0)) |-> !pulse_o);

    assert_hold_high_R3: assert property (@(posedge clk_i) disable iff (rst_i || !en_i)
        (pulse_o && !fire_i && remain_q > cnt_t'(1)) |=> pulse_o);

endmodule

// File: rtl/pwm2t_top.sv
module pwm2t_top
    import pwm2t_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pwm_o,
    output logic             trig_o
);

    logic tick;

    pwm2t_period_tmr u_period (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .period_i (period_i),
        .trig_o   (tick)
    );

    pwm2t_oneshot u_oneshot (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .fire_i  (tick),
        .width_i (width_i),
        .pulse_o (pwm_o)
    );

    assign trig_o = tick;

    assert_off_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> (!pwm_o && !trig_o));

    // A high time not shorter than the period leaves no gap at the boundary
    assert_full_width_R5: assert property (@(posedge clk_i) disable iff (rst_i || !en_i)
        (trig_o && width_i >= period_i && width_i != '0) |-> pwm_o);

endmodule

// File: tb/pwm2t_top_bench.sv
module pwm2t_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [15:0] period;
    logic [15:0] width;
    logic        pwm;
    logic        trig;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pwm2t_top u_pwm2t_top (
        .clk_i    (clk),
        .rst_i    (rst),
        .en_i     (en),
        .period_i (period),
        .width_i  (width),
        .pwm_o    (pwm),
        .trig_o   (trig)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input int k);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d P=%0d W=%0d: actual %b expected %b",
                     tag, k, period, width, act, exp);
        end
    endtask

    // Sample one time unit after the falling edge, then step to the next one
    task automatic check_cycle(input int k, input logic e_trig, input logic e_pwm, input string tag);
        #1;
        chk(trig, e_trig, {tag, " trig"}, k);
        chk(pwm,  e_pwm,  {tag, " pwm"},  k);
        @(negedge clk);
    endtask

    task automatic run_case(input int p, input int w);
        int ep;
        string tag;
        ep = (p < 1) ? 1 : p;
        if (w == 0) tag = "R4";
        else if (w >= ep) tag = "R5";
        else tag = "R3";
        en = 1'b0;
        @(negedge clk);
        period = 16'(p);
        width  = 16'(w);
        en     = 1'b1;
        for (int k = 0; k < 3 * ep + 2; k++) begin
            check_cycle(k, ((k % ep) == 0), ((k % ep) < w),
                        (k == 0) ? "R2" : ((k % ep) == 0 ? "R1" : tag));
        end
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; period = '0; width = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(pwm,  1'b0, "R8 pwm",  0);
        chk(trig, 1'b0, "R8 trig", 0);
        @(negedge clk);

        for (int p = 0; p <= 8; p++) begin
            for (int w = 0; w <= 9; w++) begin
                run_case(p, w);
            end
        end

        // R6: mid-period change has no effect until the next trigger
        en = 1'b0;
        @(negedge clk);
        period = 16'd6; width = 16'd2; en = 1'b1;
        for (int k = 0; k < 14; k++) begin
            logic et, ep_;
            if (k == 3) begin
                period = 16'd4; width = 16'd5;
            end
            if (k < 6) begin
                et = (k == 0); ep_ = (k < 2);
            end else begin
                et = (((k - 6) % 4) == 0); ep_ = 1'b1;
            end
            check_cycle(k, et, ep_, "R6");
        end

        // R7: disable mid-pulse, outputs low, restart at a trigger
        en = 1'b0;
        @(negedge clk);
        period = 16'd5; width = 16'd3; en = 1'b1;
        check_cycle(0, 1'b1, 1'b1, "R7");
        check_cycle(1, 1'b0, 1'b1, "R7");
        en = 1'b0;
        check_cycle(2, 1'b0, 1'b0, "R7");
        check_cycle(3, 1'b0, 1'b0, "R7");
        check_cycle(4, 1'b0, 1'b0, "R7");
        en = 1'b1;
        for (int k = 0; k < 10; k++) begin
            check_cycle(k, ((k % 5) == 0), ((k % 5) < 3), "R7");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule